// File: doc/BRIEF.md
# Boot ROM Expansion Bus Controller

This block carries single-byte read and write transfers between an internal requester and an external parallel EPROM or Flash boot device. The external bus has few pins. A 24-bit address is split three ways. Bits [23:16] are placed on a shared 8-bit address bus and clocked into an external edge-triggered latch by a rising edge on the combined strobe / output-enable line. Bits [15:8] travel on a dedicated middle-address bus. Bits [7:0] replace the upper byte on the shared bus during the data phase. Data moves over a separate 8-bit bus, which is given here as output, output-enable and input.

A requester raises `req_valid` while `req_ready` is high. The controller captures the address, the direction, the write byte and the wait setting, and then runs the access alone. When the access ends it pulses `rsp_done`, and on reads the captured byte is on `rsp_rdata`. The data phase lasts `cfg_wait + 3` bus clock cycles.

States: `ST_IDLE` (bus parked, ready), `ST_ADDR` (strobe low, upper byte shown), `ST_STRB` (strobe high, which makes the rising edge), `ST_DATA` (chip select low for the timed phase), `ST_RECOV` (chip select high, done pulse). Transitions: `ST_IDLE`→`ST_ADDR` on an accepted request; `ST_ADDR`→`ST_STRB` and `ST_STRB`→`ST_DATA` take one cycle each, always; `ST_DATA`→`ST_RECOV` on the last data cycle; `ST_RECOV`→`ST_IDLE` always.

Top module: `bootrom_bus_ctrl`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken only on a cycle where `req_valid` and `req_ready` are both high. Changes to the request inputs during an access do not affect that access and do not start another one.
- R2: Each access opens with one cycle of `bus_stb_oe` low and then one cycle of it high, so there is a rising edge. In both cycles `bus_ad_o` carries address bits [23:16] and `bus_cs_n` stays high.
- R3: `bus_cs_n` is low for exactly `cfg_wait + 3` consecutive cycles per access, where `cfg_wait` is the value sampled when the request was accepted.
- R4: While `bus_cs_n` is low, `bus_ad_o` carries address bits [7:0] and `bus_am_o` carries address bits [15:8].
- R5: On a read (`req_write` = 0), `bus_stb_oe` is low, `bus_we_n` is high and `bus_d_oe` is low for the whole data phase.
- R6: On a write (`req_write` = 1), `bus_stb_oe` stays high and `bus_d_oe` is high with the write byte on `bus_d_o` for the whole data phase. `bus_we_n` is low from the second data cycle through the next-to-last data cycle.
- R7: Read data is taken from `bus_d_i` on the last data cycle only. `rsp_done` is a one-cycle pulse in the cycle after `bus_cs_n` rises, and on reads `rsp_rdata` holds the captured byte at that time.
- R8: When no access is in progress, `bus_ad_o`, `bus_am_o` and `bus_d_o` are all zero, `bus_d_oe` is low, and `bus_cs_n`, `bus_stb_oe` and `bus_we_n` are high.
- R9: Between two data phases there are at least two cycles with `bus_cs_n` high, including when requests arrive back to back.
- R10: After reset the block is idle, with the parked levels of R8, `req_ready` high and `rsp_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Write byte |
| cfg_wait | input | 4 | Extra data-phase cycles (phase = cfg_wait + 3) |
| rsp_rdata | output | 8 | Captured read byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_ad_o | output | 8 | Shared upper/low address bus |
| bus_am_o | output | 8 | Middle address bus |
| bus_d_o | output | 8 | Data bus, driven value |
| bus_d_oe | output | 1 | Data bus drive enable |
| bus_d_i | input | 8 | Data bus, sampled value |
| bus_cs_n | output | 1 | Boot device chip select, active low |
| bus_stb_oe | output | 1 | Address strobe (rising edge) / read output enable (low) |
| bus_we_n | output | 1 | Flash write enable, active low |

## Verification
Two things can fall on the same clock edge. The read byte is captured on the last data cycle, and on that same edge chip select is released and the completion is prepared. The bench drives the inverted byte on `bus_d_i` in every data cycle except the last one. It then checks that `rsp_rdata` equals the last-cycle value exactly when `rsp_done` rises. A second overlap happens when a new request is already waiting while the previous access finishes. Keeping `req_valid` high through the recovery cycle must give a fresh strobe sequence, with chip select high for two cycles in between. Changes to the request inputs in the middle of an access must have no effect on the bus.

// File: rtl/bootrom_pkg.sv
package bootrom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_STRB  = 3'd2,
        ST_DATA  = 3'd3,
        ST_RECOV = 3'd4
    } brc_state_e;
endpackage

// File: rtl/brc_req_hold.sv
module brc_req_hold #(
    parameter int AW = 24,
    parameter int DW = 8,
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          in_write,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic [WW-1:0] in_wait,
    output logic          hold_write,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_wdata,
    output logic [WW-1:0] hold_wait
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_write <= 1'b0;
            hold_addr  <= '0;
            hold_wdata <= '0;
            hold_wait  <= '0;
        end else if (load) begin
            hold_write <= in_write;
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
            hold_wait  <= in_wait;
        end
    end
endmodule

// File: rtl/brc_phase_timer.sv
module brc_phase_timer #(
    parameter int WW = 4,
    localparam int CW = WW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [WW-1:0] wait_cyc,
    output logic          first,
    output logic          last
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] len_m1;

    assign len_m1 = {1'b0, wait_cyc} + CW'(2);
    assign first  = (cnt == '0);
    assign last   = (cnt == len_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= len_m1));
endmodule

// File: rtl/bootrom_bus_ctrl.sv
module bootrom_bus_ctrl
    import bootrom_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 8,
    parameter int WW = 4,
    localparam int BW = AW / 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [WW-1:0] cfg_wait,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic [BW-1:0] bus_ad_o,
    output logic [BW-1:0] bus_am_o,
    output logic [DW-1:0] bus_d_o,
    output logic          bus_d_oe,
    input  logic [DW-1:0] bus_d_i,
    output logic          bus_cs_n,
    output logic          bus_stb_oe,
    output logic          bus_we_n
);
    brc_state_e    state, state_nx;
    logic          accept;
    logic          h_write;
    logic [AW-1:0] h_addr;
    logic [DW-1:0] h_wdata;
    logic [WW-1:0] h_wait;
    logic          in_data;
    logic          ph_first, ph_last;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign in_data = (state == ST_DATA);

    brc_req_hold #(.AW(AW), .DW(DW), .WW(WW)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .in_write(req_write), .in_addr(req_addr),
        .in_wdata(req_wdata), .in_wait(cfg_wait),
        .hold_write(h_write), .hold_addr(h_addr),
        .hold_wdata(h_wdata), .hold_wait(h_wait)
    );

    brc_phase_timer #(.WW(WW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(in_data),
        .wait_cyc(h_wait), .first(ph_first), .last(ph_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_ADDR;
            ST_ADDR:  state_nx = ST_STRB;
            ST_STRB:  state_nx = ST_DATA;
            ST_DATA:  if (ph_last) state_nx = ST_RECOV;
            ST_RECOV: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // read capture on final data cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rsp_rdata <= '0;
        else if (in_data && ph_last && !h_write)
            rsp_rdata <= bus_d_i;
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        rsp_done   = 1'b0;
        bus_ad_o   = '0;
        bus_am_o   = '0;
        bus_d_o    = '0;
        bus_d_oe   = 1'b0;
        bus_cs_n   = 1'b1;
        bus_stb_oe = 1'b1;
        bus_we_n   = 1'b1;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_ADDR: begin
                bus_ad_o   = h_addr[3*BW-1:2*BW];
                bus_stb_oe = 1'b0;
            end
            ST_STRB:  bus_ad_o = h_addr[3*BW-1:2*BW];
            ST_DATA: begin
                bus_cs_n = 1'b0;
                bus_ad_o = h_addr[BW-1:0];
                bus_am_o = h_addr[2*BW-1:BW];
                if (h_write) begin
                    bus_d_o  = h_wdata;
                    bus_d_oe = 1'b1;
                    bus_we_n = ph_first || ph_last;
                end else begin
                    bus_stb_oe = 1'b0;
                end
            end
            ST_RECOV: rsp_done = 1'b1;
            default: ;
        endcase
    end

    p_ready_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_stb_oe && bus_we_n && !bus_d_oe));
    p_strobe_before_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> ($past(bus_stb_oe) && !$past(bus_stb_oe, 2)));
    p_read_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !bus_stb_oe) |-> (!bus_d_oe && bus_we_n));
    p_we_after_cs_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> (!bus_cs_n && !$past(bus_cs_n) && bus_d_oe));
    p_we_before_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |=> !bus_cs_n);
    p_done_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_cs_n && !$past(bus_cs_n)));
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |=> bus_cs_n);
endmodule

// File: tb/bootrom_bus_ctrl_tb_top.sv
module bootrom_bus_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [3:0]  cfg_wait = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [7:0]  bus_ad_o, bus_am_o, bus_d_o;
    logic        bus_d_oe;
    logic [7:0]  bus_d_i = '0;
    logic        bus_cs_n, bus_stb_oe, bus_we_n;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bootrom_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_wait(cfg_wait), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .bus_ad_o(bus_ad_o), .bus_am_o(bus_am_o), .bus_d_o(bus_d_o),
        .bus_d_oe(bus_d_oe), .bus_d_i(bus_d_i), .bus_cs_n(bus_cs_n),
        .bus_stb_oe(bus_stb_oe), .bus_we_n(bus_we_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pk();
        return {bus_ad_o, bus_am_o, bus_d_oe, bus_cs_n, bus_stb_oe, bus_we_n,
                rsp_done, req_ready, 2'b0, bus_d_o};
    endfunction

    task automatic chk_parked(input string req);
        logic [31:0] e;
        e = {8'h0, 8'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 8'h0};
        chk(pk() == e, req, pk(), e);
    endtask

    // One access from an idle negedge; leaves the bench on the next idle negedge.
    task automatic run_access(input bit wr, input logic [23:0] a, input logic [7:0] wd,
                              input logic [3:0] w, input logic [7:0] rd,
                              input bit keep_valid);
        int n;
        n = int'(w) + 3;
        chk(req_ready === 1'b1, "R1 ready before request", {31'b0, req_ready}, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; cfg_wait = w;
        @(negedge clk);
        // ST_ADDR: scramble request inputs (R1 ignored while busy)
        req_valid = keep_valid; req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
        cfg_wait = ~w;
        chk(!bus_stb_oe && bus_cs_n && bus_ad_o == a[23:16] && !req_ready,
            "R2 strobe low phase", pk(), {a[23:16], 24'h0});
        @(negedge clk);
        chk(bus_stb_oe && bus_cs_n && bus_ad_o == a[23:16],
            "R2 strobe high phase", pk(), {a[23:16], 24'h0});
        for (int i = 0; i < n; i++) begin
            bus_d_i = (i == n - 1) ? rd : ~rd;
            @(negedge clk);
            chk(!bus_cs_n, "R3 cs low in data phase", {31'b0, bus_cs_n}, 0);
            chk(bus_ad_o == a[7:0] && bus_am_o == a[15:8], "R4 data-phase address",
                {16'h0, bus_ad_o, bus_am_o}, {16'h0, a[7:0], a[15:8]});
            if (wr) begin
                chk(bus_stb_oe && bus_d_oe && bus_d_o == wd, "R6 write drive",
                    pk(), {16'h0, wd, 8'h0});
                chk(bus_we_n == !(i >= 1 && i <= n - 2), "R6 we window",
                    {31'b0, bus_we_n}, {31'b0, !(i >= 1 && i <= n - 2)});
            end else begin
                chk(!bus_stb_oe && bus_we_n && !bus_d_oe, "R5 read strobes", pk(), 0);
            end
        end
        @(negedge clk);
        bus_d_i = 8'h00;
        chk(bus_cs_n, "R3 cs released after phase", {31'b0, bus_cs_n}, 1);
        chk(rsp_done, "R7 done pulse", {31'b0, rsp_done}, 1);
        if (!wr) chk(rsp_rdata == rd, "R7 read data", {24'h0, rsp_rdata}, {24'h0, rd});
        if (!keep_valid) begin
            @(negedge clk);
            chk(!rsp_done, "R7 done single cycle", {31'b0, rsp_done}, 0);
            chk_parked("R8 parked after access");
        end else begin
            req_valid = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_parked("R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        chk_parked("R10 after reset release");
    endtask

    task automatic t_reads();
        run_access(1'b0, 24'hA5_3C_71, 8'h00, 4'd0, 8'h5A, 1'b0);
        run_access(1'b0, 24'h12_34_56, 8'h00, 4'd5, 8'hC3, 1'b0);
        run_access(1'b0, 24'hFF_00_FF, 8'h00, 4'd15, 8'h81, 1'b0);
    endtask

    task automatic t_writes();
        run_access(1'b1, 24'h0F_E1_2D, 8'h96, 4'd0, 8'h00, 1'b0);
        run_access(1'b1, 24'h80_7F_01, 8'h3E, 4'd7, 8'h00, 1'b0);
    endtask

    task automatic t_busy_ignore();
        // R1: valid held during access but dropped before idle -> no new access
        run_access(1'b0, 24'h44_55_66, 8'h00, 4'd2, 8'h77, 1'b1);
        // bench now at ST_IDLE negedge with valid low
        for (int k = 0; k < 4; k++) begin
            chk(bus_cs_n && bus_stb_oe, "R1 no spurious access", pk(), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_back_to_back();
        int gap;
        bit seen_low;
        // R9: request already waiting when idle returns
        run_access(1'b1, 24'h01_02_03, 8'hAA, 4'd1, 8'h00, 1'b0);
        run_access(1'b0, 24'h04_05_06, 8'h00, 4'd1, 8'h99, 1'b0);
        // measure cs-high gap with continuous valid
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h111111; cfg_wait = 4'd0;
        gap = 0; seen_low = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!bus_cs_n) seen_low = 1'b1;
            else if (seen_low) gap++;
            if (seen_low && !bus_cs_n && gap > 0) break;
        end
        req_valid = 1'b0;
        chk(gap >= 2, "R9 cs high gap", gap, 2);
        repeat (12) @(negedge clk);
        chk_parked("R8 parked after burst");
    endtask

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_reads();
        t_writes();
        t_busy_ignore();
        t_back_to_back();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule